// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block sits inside a DDR SDRAM controller and decides when an AUTO REFRESH command goes out. A free-running interval timer fires once every average refresh period and adds one owed refresh to a debt counter. While the debt is non-zero, the scheduler first asks for all banks to be closed through a precharge-all handshake. It then requests a refresh slot from the command arbiter through a request/grant pair. Each granted slot produces a one-cycle refresh command with an all-zero address. After that, the bus is held for the refresh cycle time.

Below the debt ceiling, a refresh is only started while the arbiter reports an idle bus, so refreshes can be put off during busy traffic. Once the debt reaches its ceiling, the request is marked urgent and is started regardless of bus activity. The arbiter must then serve it ahead of normal traffic. The timer period in clocks is derived from the clock frequency and the refresh interval in nanoseconds. The ceiling and the refresh cycle time are parameters.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer fires every TREFI_CLKS = CLK_MHZ*TREFI_NS/1000 clock cycles, and each firing raises the debt by one. With the bench settings of 200 MHz and 200 ns, that is 40 cycles: the debt becomes 1 at the 40th rising edge after reset release.
- R2: A refresh sequence starts by raising pre_req one cycle after the scheduler, while idle, sees a non-zero debt together with an idle bus or an urgent debt. pre_req stays high until pre_ack is sampled, and ref_req is never raised before that acknowledge.
- R3: ref_req rises in the cycle after pre_ack is sampled and stays high until ref_gnt is sampled. While ref_req is high, ref_urgent equals 1 exactly when the debt equals DEBT_MAX.
- R4: While bus_idle is low and the debt is below DEBT_MAX, no new sequence is started: pre_req stays low.
- R5: ref_cmd is high for exactly one cycle, in the cycle after ref_gnt is sampled with ref_req high. ref_addr is all zeros.
- R6: Each refresh command lowers the debt by exactly one at the clock edge that ends the command cycle. If a timer firing lands on that same edge, the debt is left unchanged.
- R7: The debt saturates at DEBT_MAX (8): further timer firings at the ceiling do not change it.
- R8: hold is high for exactly TRFC_CLKS cycles, starting with the command cycle. No pre_req or ref_req is raised while hold is high.
- R9: A synchronous reset clears the debt and the timer, and drives pre_req, ref_req, ref_cmd and hold low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_idle | input | 1 | Arbiter reports no normal traffic pending |
| pre_ack | input | 1 | Precharge-all has completed |
| ref_gnt | input | 1 | Arbiter grants the refresh slot |
| pre_req | output | 1 | Request precharge of all banks |
| ref_req | output | 1 | Request a refresh slot |
| ref_urgent | output | 1 | Refresh request must be served ahead of traffic |
| ref_cmd | output | 1 | One-cycle refresh command strobe |
| ref_addr | output | ADDR_W | Address during refresh (all zeros) |
| hold | output | 1 | Bus held for the refresh cycle time |
| debt | output | DW | Number of refreshes currently owed |

## Verification
The timer firing and the debt decrement of a refresh command can land on the same clock edge. In that case the debt must stay where it was, both at the DEBT_MAX ceiling and below it. The bench provokes this by keeping its own model of the timer phase and delaying the grant until the command cycle ends exactly on a firing edge. It then compares the observed debt with the value before the command. The same model tracks the debt through every other grant pattern, so that coinciding and separate edges are both judged against an independently computed count.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_PRE  = 3'd1,
        RS_REQ  = 3'd2,
        RS_CMD  = 3'd3,
        RS_RFC  = 3'd4
    } rs_state_e;

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int PERIOD = 1560,
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(PERIOD - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R1: the counter restarts after each firing
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
    parameter int DEBT_MAX = 8,
    localparam int DW = $clog2(DEBT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          dec,
    output logic [DW-1:0] debt,
    output logic          pending,
    output logic          urgent
);
    logic [DW-1:0] debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        case ({tick, dec})
            2'b10:   debt_d = (debt_q == DW'(DEBT_MAX)) ? debt_q : debt_q + 1'b1;
            2'b01:   debt_d = (debt_q == '0) ? debt_q : debt_q - 1'b1;
            default: debt_d = debt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) debt_q <= '0;
        else     debt_q <= debt_d;
    end

    assign debt    = debt_q;
    assign pending = (debt_q != '0);
    assign urgent  = (debt_q == DW'(DEBT_MAX));

    // R7: firing at the ceiling leaves the debt at the ceiling
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (urgent && tick && !dec) |=> (debt_q == DW'(DEBT_MAX)));

    // R6: one command removes one owed refresh
    p_dec_one_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && !tick) |=> (debt_q == $past(debt_q) - 1'b1));

    // R6: firing and command on one edge cancel out
    p_tick_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && tick) |=> $stable(debt_q));

    // R9: reset clears the debt
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (debt_q == '0));

endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int TRFC_CLKS = 16,
    localparam int RW = (TRFC_CLKS > 2) ? $clog2(TRFC_CLKS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic urgent,
    input  logic bus_idle,
    input  logic pre_ack,
    input  logic ref_gnt,
    output logic pre_req,
    output logic ref_req,
    output logic ref_cmd,
    output logic hold
);
    typedef struct packed {
        rs_state_e     st;
        logic [RW-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RS_IDLE: if (pending && (bus_idle || urgent)) r_d.st = RS_PRE;
            RS_PRE:  if (pre_ack) r_d.st = RS_REQ;
            RS_REQ: begin
                if (ref_gnt) begin
                    r_d.st  = RS_CMD;
                    r_d.cnt = '0;
                end
            end
            RS_CMD, RS_RFC: begin
                if (r_q.cnt == RW'(TRFC_CLKS - 1)) begin
                    r_d.st = RS_IDLE;
                end else begin
                    r_d.st  = RS_RFC;
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= RS_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pre_req = (r_q.st == RS_PRE);
    assign ref_req = (r_q.st == RS_REQ);
    assign ref_cmd = (r_q.st == RS_CMD);
    assign hold    = (r_q.st == RS_CMD) || (r_q.st == RS_RFC);

    // R2: the refresh request only follows an acknowledged precharge
    p_pre_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_req) |-> $past(pre_req && pre_ack));

    // R4: no start while the bus is busy and the debt is not urgent
    p_defer_r4: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == RS_IDLE && !bus_idle && !urgent) |=> !pre_req);

    // R5: a command only follows a grant, and lasts one cycle
    p_cmd_gnt_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_cmd) |-> $past(ref_req && ref_gnt));
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ref_cmd |=> !ref_cmd);

    // R8: a new sequence never starts straight out of the hold window
    p_no_start_in_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_req) |-> !$past(hold));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int CLK_MHZ   = 200,
    parameter int TREFI_NS  = 7800,
    parameter int DEBT_MAX  = 8,
    parameter int TRFC_CLKS = 16,
    parameter int ADDR_W    = 13,
    localparam int DW = $clog2(DEBT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_idle,
    input  logic              pre_ack,
    input  logic              ref_gnt,
    output logic              pre_req,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              ref_cmd,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              hold,
    output logic [DW-1:0]     debt
);
    localparam int TREFI_CLKS = (CLK_MHZ * TREFI_NS) / 1000;

    logic tick, pending, urgent;

    refsched_timer #(.PERIOD(TREFI_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    refsched_debt #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .dec     (ref_cmd),
        .debt    (debt),
        .pending (pending),
        .urgent  (urgent)
    );

    refsched_fsm #(.TRFC_CLKS(TRFC_CLKS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pending  (pending),
        .urgent   (urgent),
        .bus_idle (bus_idle),
        .pre_ack  (pre_ack),
        .ref_gnt  (ref_gnt),
        .pre_req  (pre_req),
        .ref_req  (ref_req),
        .ref_cmd  (ref_cmd),
        .hold     (hold)
    );

    assign ref_urgent = ref_req && urgent;
    assign ref_addr   = '0;

    // R3: urgency is only flagged on an active request
    p_urgent_r3: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);

    // R9: reset leaves every request and command low
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!pre_req && !ref_req && !ref_cmd && !hold));

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int TREFI = 40;
    localparam int TRFC  = 4;
    localparam int MAXD  = 8;
    localparam int AW    = 13;
    localparam int DW    = $clog2(MAXD + 1);

    typedef struct packed {
        logic       idle;
        logic [3:0] ack_dly;
        logic [3:0] gnt_dly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 4'd0, 4'd0},
        '{1'b0, 4'd2, 4'd1},
        '{1'b1, 4'd0, 4'd0},
        '{1'b1, 4'd1, 4'd3},
        '{1'b1, 4'd0, 4'd0},
        '{1'b0, 4'd0, 4'd2},
        '{1'b1, 4'd3, 4'd0},
        '{1'b1, 4'd0, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_idle = 1'b0, pre_ack = 1'b0, ref_gnt = 1'b0;
    logic pre_req, ref_req, ref_urgent, ref_cmd, hold;
    logic [AW-1:0] ref_addr;
    logic [DW-1:0] debt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    int m_cnt  = 0;
    int m_debt = 0;

    always #2.5 clk = ~clk;

    refresh_sched #(
        .CLK_MHZ(200), .TREFI_NS(200), .DEBT_MAX(MAXD),
        .TRFC_CLKS(TRFC), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst(rst), .bus_idle(bus_idle), .pre_ack(pre_ack),
        .ref_gnt(ref_gnt), .pre_req(pre_req), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_cmd(ref_cmd), .ref_addr(ref_addr),
        .hold(hold), .debt(debt)
    );

    // Reference model of the owed-refresh count, built from R1, R6, R7, R9
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_debt = 0;
        end else begin
            int nd;
            bit tk;
            tk = (m_cnt == TREFI - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            nd = m_debt + (tk ? 1 : 0) - (ref_cmd ? 1 : 0);
            if (nd > MAXD) nd = MAXD;
            if (nd < 0) nd = 0;
            m_debt = nd;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic serve(input logic idle, input int ack_dly, input int gnt_dly, input bit align);
        int w;
        int d0;
        int hc;
        bus_idle = idle;
        w = 0;
        while (!pre_req && w < 600) begin
            @(negedge clk);
            w++;
        end
        chk("R2 pre_req raised", int'(pre_req), 1);
        chk("R2 no ref_req before ack", int'(ref_req), 0);
        for (int k = 0; k < ack_dly; k++) begin
            @(negedge clk);
            chk("R2 ref_req waits for ack", int'(ref_req), 0);
            chk("R2 pre_req held", int'(pre_req), 1);
        end
        pre_ack = 1'b1;
        @(negedge clk);
        pre_ack = 1'b0;
        chk("R3 ref_req after ack", int'(ref_req), 1);
        chk("R2 pre_req dropped", int'(pre_req), 0);
        chk("R3 urgency flag", int'(ref_urgent), int'(m_debt == MAXD));
        for (int k = 0; k < gnt_dly; k++) begin
            @(negedge clk);
            chk("R5 no cmd without grant", int'(ref_cmd), 0);
            chk("R3 request held", int'(ref_req), 1);
        end
        if (align) begin
            while (m_cnt != TREFI - 2) @(negedge clk);
        end
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R5 cmd after grant", int'(ref_cmd), 1);
        chk("R5 address zero", int'(ref_addr), 0);
        chk("R8 hold in cmd cycle", int'(hold), 1);
        d0 = int'(debt);
        hc = 0;
        while (hold && hc < 50) begin
            hc++;
            chk("R8 no request during hold", int'(pre_req || ref_req), 0);
            @(negedge clk);
            if (hc == 1) begin
                chk("R5 single cycle cmd", int'(ref_cmd), 0);
                chk("R6 debt after cmd", int'(debt), m_debt);
                if (align) chk("R6 tick with cmd keeps debt", int'(debt), d0);
            end
        end
        chk("R8 hold length", hc, TRFC);
        d0 = m_debt;
        @(negedge clk);
        chk("R4 start rule after refresh", int'(pre_req),
            int'(d0 > 0 && (idle || d0 == MAXD)));
    endtask

    task automatic reset_and_interval;
        rst = 1'b1;
        bus_idle = 1'b0;
        pre_ack = 1'b0;
        ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset debt", int'(debt), 0);
        chk("R9 reset outputs", int'({pre_req, ref_req, ref_cmd, hold}), 0);
        rst = 1'b0;
        repeat (TREFI - 1) @(negedge clk);
        chk("R1 no firing before period", int'(debt), 0);
        @(negedge clk);
        chk("R1 firing at period", int'(debt), 1);
    endtask

    initial begin
        reset_and_interval();
        repeat (60) @(negedge clk);
        chk("R4 busy bus defers", int'(pre_req), 0);
        chk("R1 debt after 100 cycles", int'(debt), 2);
        repeat (300) @(negedge clk);
        chk("R7 saturated debt", int'(debt), MAXD);
        chk("R2 urgent start", int'(pre_req), 1);
        chk("R2 no ref_req without ack", int'(ref_req), 0);

        foreach (VECS[i]) begin
            serve(VECS[i].idle, int'(VECS[i].ack_dly), int'(VECS[i].gnt_dly), 1'b0);
        end

        // coinciding firing and command at the ceiling (R6, R7)
        serve(1'b0, 0, 0, 1'b1);
        // coinciding firing and command below the ceiling (R6)
        serve(1'b1, 1, 0, 1'b1);
        chk("R6 model agreement", int'(debt), m_debt);

        // mid-run reset (R9) then interval again (R1)
        reset_and_interval();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule